// File: doc/BRIEF.md
# Sync-Gated Input FIFO

This block is a synchronous FIFO whose write side and read side are each opened or held shut by a mode field in a small control register. The write side can accept words all the time, or stay shut until the first rising edge of the sync0 input, or refuse everything. The read side can deliver words all the time, or open a programmed number of clocks after a rising edge on sync0 or on sync1, or refuse everything. Each read trigger has its own 16-bit delay register.

Configuration uses one write port with a 2-bit register select. Select 0 is the control register: bits [3:2] hold the write mode and bits [5:4] hold the read mode. Select 1 holds the delay that applies after sync0. Select 2 holds the delay that applies after sync1. Select 3 is ignored. Words enter through a valid/data input and leave through a request input. Read data is registered and comes with a one-cycle valid strobe. The block has full and empty flags, plus sticky flags that record a write refused because the FIFO was full and a read refused because it was empty.

Top module: `sync_gate_fifo`

## Requirements
- R1: After rst_ni is released, empty_o=1, full_o=0, out_valid_o=0, ovf_o=0 and udf_o=0. Both modes are 00, so words are accepted and read immediately.
- R2: Write mode, control bits [3:2]. With bit 3 = 1 the value of bit 2 does not matter: in_valid_i is ignored, stored words are kept and ovf_o does not change.
- R3: Write mode 01 refuses words until sync0_i is sampled high after being low. Words are accepted from the next clock onward and stay accepted until the control register is written again.
- R4: Read mode, control bits [5:4]. Value 11 ignores rd_req_i: no out_valid_o and no udf_o. Writes continue until the FIFO is full. Value 00 reads continuously.
- R5: Read mode 01 opens reads D0+1 clocks after the clock at which a rising sync0_i is sampled, where D0 is the delay at select 1. With D0=0, reads open on the next clock.
- R6: Read mode 10 behaves as R5 but uses sync1_i and the delay at select 2. Edges on sync0_i have no effect on reads in this mode.
- R7: A write to the control register clears any write arming, any open read gate and any running delay count. The new mode then waits for a fresh sync edge.
- R8: Words leave in the order they were written, up to DEPTH entries (default 16). out_data_o is valid, with out_valid_o high, on the clock after an accepted read.
- R9: A write attempt that is enabled but arrives while full_o=1 is dropped and sets ovf_o, which stays set until reset.
- R10: A read attempt that is enabled but arrives while empty_o=1 produces no out_valid_o and sets udf_o, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Register select: 0 control, 1 sync0 delay, 2 sync1 delay |
| cfg_wdata_i | input | DLY_W | Configuration write data |
| sync0_i | input | 1 | Sync input 0 (rising edge used) |
| sync1_i | input | 1 | Sync input 1 (rising edge used) |
| in_valid_i | input | 1 | Write attempt |
| in_data_i | input | DW | Write data |
| full_o | output | 1 | FIFO full |
| rd_req_i | input | 1 | Read attempt |
| out_valid_o | output | 1 | Read data valid strobe |
| out_data_o | output | DW | Registered read data |
| empty_o | output | 1 | FIFO empty |
| ovf_o | output | 1 | Sticky overflow flag |
| udf_o | output | 1 | Sticky underflow flag |

## Verification
The bench builds the block with DEPTH=4, DW=16 and DLY_W=16. The shallow FIFO makes full and empty frequent under random traffic, so overflow and underflow attempts, and reads arriving on the same clock as a gate opening, occur often. Delays are kept between 0 and 6, so many sync-to-read windows, including the zero-delay case, fit in the run. Mode rewrites that land in the middle of a count are also common.

// File: rtl/sgf_pkg.sv
package sgf_pkg;
  typedef enum logic [1:0] {
    WR_FREE  = 2'b00,
    WR_ON_S0 = 2'b01,
    WR_OFF_A = 2'b10,
    WR_OFF_B = 2'b11
  } wr_mode_e;

  typedef enum logic [1:0] {
    RD_FREE     = 2'b00,
    RD_AFTER_S0 = 2'b01,
    RD_AFTER_S1 = 2'b10,
    RD_OFF      = 2'b11
  } rd_mode_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_DLY0 = 2'd1;
  localparam logic [1:0] SEL_DLY1 = 2'd2;

  localparam int unsigned WR_LSB   = 2;
  localparam int unsigned RD_LSB   = 4;
  localparam int unsigned NUM_SYNC = 2;
endpackage

// File: rtl/sgf_regs.sv
module sgf_regs
  import sgf_pkg::*;
#(
  parameter int unsigned DLY_W = 16
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               cfg_we_i,
  input  logic [1:0]                         cfg_addr_i,
  input  logic [DLY_W-1:0]                   cfg_wdata_i,
  output wr_mode_e                           wr_mode_o,
  output rd_mode_e                           rd_mode_o,
  output logic                               mode_upd_o,
  output logic [NUM_SYNC-1:0][DLY_W-1:0]     dly_o
);
  wr_mode_e wr_mode_q;
  rd_mode_e rd_mode_q;
  logic [NUM_SYNC-1:0][DLY_W-1:0] dly_q;

  assign mode_upd_o = cfg_we_i && (cfg_addr_i == SEL_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_mode_q <= WR_FREE;
      rd_mode_q <= RD_FREE;
      dly_q     <= '0;
    end else if (cfg_we_i) begin
      unique case (cfg_addr_i)
        SEL_CTRL: begin
          wr_mode_q <= wr_mode_e'(cfg_wdata_i[WR_LSB +: 2]);
          rd_mode_q <= rd_mode_e'(cfg_wdata_i[RD_LSB +: 2]);
        end
        SEL_DLY0: dly_q[0] <= cfg_wdata_i;
        SEL_DLY1: dly_q[1] <= cfg_wdata_i;
        default: ;
      endcase
    end
  end

  assign wr_mode_o = wr_mode_q;
  assign rd_mode_o = rd_mode_q;
  assign dly_o     = dly_q;
endmodule

// File: rtl/sgf_sync_timer.sv
module sgf_sync_timer #(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             arm_i,
  input  logic             rise_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             open_o
);
  logic [DLY_W-1:0] cnt_q;
  logic             run_q;
  logic             open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      open_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      open_q <= 1'b0;
    end else if (arm_i) begin
      if (run_q) begin
        if (cnt_q == DLY_W'(1)) begin
          open_q <= 1'b1;
          run_q  <= 1'b0;
        end
        cnt_q <= cnt_q - DLY_W'(1);
      end else if (!open_q && rise_i) begin
        // zero delay opens on the edge after detection
        if (dly_i == '0) begin
          open_q <= 1'b1;
        end else begin
          run_q <= 1'b1;
          cnt_q <= dly_i;
        end
      end
    end
  end

  assign open_o = open_q;
endmodule

// File: rtl/sgf_fifo.sv
module sgf_fifo #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW:0]   wp_q;
  logic [AW:0]   rp_q;

  assign empty_o = (wp_q == rp_q);
  assign full_o  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q     <= '0;
      rp_q     <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= pop_i;
      if (push_i) wp_q <= wp_q + 1'b1;
      if (pop_i) begin
        rp_q    <= rp_q + 1'b1;
        rdata_o <= mem_q[rp_q[AW-1:0]];
      end
    end
  end
endmodule

// File: rtl/sync_gate_fifo.sv
module sync_gate_fifo
  import sgf_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [DLY_W-1:0] cfg_wdata_i,
  input  logic             sync0_i,
  input  logic             sync1_i,
  input  logic             in_valid_i,
  input  logic [DW-1:0]    in_data_i,
  output logic             full_o,
  input  logic             rd_req_i,
  output logic             out_valid_o,
  output logic [DW-1:0]    out_data_o,
  output logic             empty_o,
  output logic             ovf_o,
  output logic             udf_o
);
  wr_mode_e wr_mode;
  rd_mode_e rd_mode;
  logic     mode_upd;
  logic [NUM_SYNC-1:0][DLY_W-1:0] dly;
  logic [NUM_SYNC-1:0] sync_vec, sync_q, rise, rd_open;
  logic wr_open, wr_en, rd_en, push_try, pop_try, push, pop;

  sgf_regs #(.DLY_W(DLY_W)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .wr_mode_o(wr_mode), .rd_mode_o(rd_mode), .mode_upd_o(mode_upd), .dly_o(dly)
  );

  assign sync_vec = {sync1_i, sync0_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_vec;
  end

  assign rise = sync_vec & ~sync_q;

  // write arming is a zero-delay timer on sync0
  sgf_sync_timer #(.DLY_W(DLY_W)) u_wr_arm (
    .clk_i, .rst_ni, .clr_i(mode_upd), .arm_i(wr_mode == WR_ON_S0),
    .rise_i(rise[0]), .dly_i('0), .open_o(wr_open)
  );

  for (genvar g = 0; g < NUM_SYNC; g++) begin : g_rd_tmr
    sgf_sync_timer #(.DLY_W(DLY_W)) u_tmr (
      .clk_i, .rst_ni, .clr_i(mode_upd),
      .arm_i(rd_mode == rd_mode_e'(2'(g + 1))),
      .rise_i(rise[g]), .dly_i(dly[g]), .open_o(rd_open[g])
    );
  end

  assign wr_en = (wr_mode == WR_FREE) || ((wr_mode == WR_ON_S0) && wr_open);

  always_comb begin
    unique case (rd_mode)
      RD_FREE:     rd_en = 1'b1;
      RD_AFTER_S0: rd_en = rd_open[0];
      RD_AFTER_S1: rd_en = rd_open[1];
      default:     rd_en = 1'b0;
    endcase
  end

  assign push_try = in_valid_i && wr_en;
  assign pop_try  = rd_req_i && rd_en;
  assign push     = push_try && !full_o;
  assign pop      = pop_try && !empty_o;

  sgf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .wdata_i(in_data_i), .pop_i(pop),
    .rdata_o(out_data_o), .rvalid_o(out_valid_o), .full_o, .empty_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o <= 1'b0;
      udf_o <= 1'b0;
    end else begin
      if (push_try && full_o) ovf_o <= 1'b1;
      if (pop_try && empty_o) udf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sync_gate_fifo_chk.sv
module sync_gate_fifo_chk
  import sgf_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_req_i,
  input logic       full_o,
  input logic       empty_o,
  input logic       out_valid_o,
  input logic       ovf_o,
  input logic       udf_o,
  input logic       wr_off_i,
  input logic [1:0] rd_mode_i
);
  // R1
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  // R2
  wr_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_off_i && empty_o) |=> empty_o);

  // R4
  rd_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_mode_i == RD_OFF) |=> !out_valid_o);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  // R9
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !rd_req_i) |=> full_o);

  // R10
  udf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udf_o |=> udf_o);

  // R10
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && empty_o) |=> !out_valid_o);
endmodule

bind sync_gate_fifo sync_gate_fifo_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_req_i    (rd_req_i),
  .full_o      (full_o),
  .empty_o     (empty_o),
  .out_valid_o (out_valid_o),
  .ovf_o       (ovf_o),
  .udf_o       (udf_o),
  .wr_off_i    (wr_mode[1]),
  .rd_mode_i   (rd_mode)
);

// File: tb/sync_gate_fifo_bench.sv
`timescale 1ns/1ps
module sync_gate_fifo_bench;
  localparam int unsigned DW    = 16;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned DLY_W = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_we_i = 1'b0;
  logic [1:0]       cfg_addr_i = '0;
  logic [DLY_W-1:0] cfg_wdata_i = '0;
  logic             sync0_i = 1'b0, sync1_i = 1'b0;
  logic             in_valid_i = 1'b0;
  logic [DW-1:0]    in_data_i = '0;
  logic             rd_req_i = 1'b0;
  logic             full_o, empty_o, out_valid_o, ovf_o, udf_o;
  logic [DW-1:0]    out_data_o;

  always #4 clk_i = ~clk_i;

  sync_gate_fifo #(.DW(DW), .DEPTH(DEPTH), .DLY_W(DLY_W)) u_sync_gate_fifo (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .sync0_i, .sync1_i,
    .in_valid_i, .in_data_i, .full_o, .rd_req_i, .out_valid_o, .out_data_o,
    .empty_o, .ovf_o, .udf_o
  );

  int    n_chk = 0, n_err = 0;
  bit    done = 0;
  string tag = "R1";

  // reference state
  logic [DW-1:0]    q[$];
  logic [1:0]       m_wr = 0, m_rd = 0;
  bit               m_wopen = 0;
  bit               m_ropen[2] = '{0, 0};
  bit               m_run[2] = '{0, 0};
  int               m_cnt[2] = '{0, 0};
  logic [DLY_W-1:0] m_dly[2] = '{0, 0};
  bit               s_q[2] = '{0, 0};
  bit               e_ovf = 0, e_udf = 0, e_ov = 0;
  logic [DW-1:0]    e_od = '0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit rise[2];
    bit wen, ren, push, pop;
    int sz;
    rise[0] = sync0_i && !s_q[0];
    rise[1] = sync1_i && !s_q[1];
    wen = (m_wr == 2'b00) || (m_wr == 2'b01 && m_wopen);
    ren = (m_rd == 2'b00) || (m_rd == 2'b01 && m_ropen[0]) || (m_rd == 2'b10 && m_ropen[1]);
    sz = q.size();
    push = in_valid_i && wen && sz < DEPTH;
    if (in_valid_i && wen && sz == DEPTH) e_ovf = 1;
    pop = rd_req_i && ren && sz > 0;
    if (rd_req_i && ren && sz == 0) e_udf = 1;
    e_ov = pop;
    if (pop) e_od = q.pop_front();
    if (push) q.push_back(in_data_i);
    if (cfg_we_i && cfg_addr_i == 2'd0) begin
      m_wr = cfg_wdata_i[3:2];
      m_rd = cfg_wdata_i[5:4];
      m_wopen = 0;
      for (int i = 0; i < 2; i++) begin m_ropen[i] = 0; m_run[i] = 0; m_cnt[i] = 0; end
    end else begin
      if (m_wr == 2'b01 && rise[0]) m_wopen = 1;
      for (int i = 0; i < 2; i++) begin
        if (int'(m_rd) == i + 1) begin
          if (m_run[i]) begin
            if (m_cnt[i] == 1) begin m_ropen[i] = 1; m_run[i] = 0; end
            m_cnt[i]--;
          end else if (!m_ropen[i] && rise[i]) begin
            if (m_dly[i] == 0) m_ropen[i] = 1;
            else begin m_run[i] = 1; m_cnt[i] = int'(m_dly[i]); end
          end
        end
      end
    end
    if (cfg_we_i && cfg_addr_i == 2'd1) m_dly[0] = cfg_wdata_i;
    if (cfg_we_i && cfg_addr_i == 2'd2) m_dly[1] = cfg_wdata_i;
    s_q[0] = sync0_i;
    s_q[1] = sync1_i;
  endtask

  task automatic compare();
    logic [4:0] act, exp;
    act = {full_o, empty_o, out_valid_o, ovf_o, udf_o};
    exp = {q.size() == DEPTH, q.size() == 0, e_ov, e_ovf, e_udf};
    chk(act === exp, tag, "flags {full,empty,valid,ovf,udf}", 32'(act), 32'(exp));
    if (e_ov) chk(out_data_o === e_od, tag, "out_data", 32'(out_data_o), 32'(e_od));
  endtask

  task automatic cycle();
    model_step();
    @(negedge clk_i);
    compare();
  endtask

  task automatic idle();
    cfg_we_i = 0; in_valid_i = 0; rd_req_i = 0;
  endtask

  task automatic cfg(logic [1:0] a, logic [DLY_W-1:0] d);
    idle();
    cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
    cycle();
    cfg_we_i = 0;
  endtask

  task automatic put(int n);
    for (int i = 0; i < n; i++) begin
      idle(); in_valid_i = 1; in_data_i = DW'($urandom);
      cycle();
    end
    idle();
  endtask

  task automatic get(int n);
    for (int i = 0; i < n; i++) begin
      idle(); rd_req_i = 1;
      cycle();
    end
    idle();
  endtask

  // sync_sel 0/1, delay d, rd_req held; first valid expected after call d+1
  task automatic delayed_read(int sel, int d, string req);
    idle(); rd_req_i = 1;
    for (int k = 0; k <= d + 2; k++) begin
      if (sel == 0) sync0_i = (k == 0); else sync1_i = (k == 0);
      cycle();
      chk(out_valid_o === (k >= d + 1), req, $sformatf("valid at k=%0d d=%0d", k, d),
          32'(out_valid_o), 32'(k >= d + 1));
    end
    sync0_i = 0; sync1_i = 0; idle();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    tag = "R1";
    compare();
    cycle();
    put(2);

    tag = "R8";
    get(2);
    put(DEPTH);
    get(DEPTH);

    tag = "R4";
    cfg(2'd0, 16'h0030);
    for (int i = 0; i < DEPTH + 1; i++) begin
      idle(); in_valid_i = 1; rd_req_i = 1; in_data_i = DW'($urandom);
      cycle();
    end
    chk(full_o === 1'b1 && udf_o === 1'b0, "R4", "full with reads off", 32'({full_o, udf_o}), 32'h2);

    tag = "R9";
    put(2);
    chk(ovf_o === 1'b1, "R9", "ovf after full write", 32'(ovf_o), 32'd1);

    tag = "R10";
    cfg(2'd0, 16'h0000);
    get(DEPTH + 1);
    chk(udf_o === 1'b1 && empty_o === 1'b1, "R10", "udf after empty read", 32'({udf_o, empty_o}), 32'h3);

    tag = "R2";
    cfg(2'd0, 16'h0008);
    put(3);
    chk(empty_o === 1'b1, "R2", "write off mode 10", 32'(empty_o), 32'd1);
    cfg(2'd0, 16'h000C);
    put(3);
    chk(empty_o === 1'b1, "R2", "write off mode 11", 32'(empty_o), 32'd1);

    tag = "R3";
    cfg(2'd0, 16'h0034);
    put(2);
    chk(empty_o === 1'b1, "R3", "write held before sync0", 32'(empty_o), 32'd1);
    idle(); in_valid_i = 1; sync0_i = 1; cycle();
    chk(empty_o === 1'b1, "R3", "no write on sync edge clock", 32'(empty_o), 32'd1);
    sync0_i = 0; in_valid_i = 1; cycle();
    chk(empty_o === 1'b0, "R3", "write after sync0", 32'(empty_o), 32'd0);
    put(3);
    chk(full_o === 1'b1, "R3", "write stays open", 32'(full_o), 32'd1);

    tag = "R5";
    cfg(2'd1, 16'd3);
    cfg(2'd0, 16'h0010);
    delayed_read(0, 3, "R5");
    get(DEPTH);
    cfg(2'd1, 16'd0);
    cfg(2'd0, 16'h0010);
    put(2);
    delayed_read(0, 0, "R5");

    tag = "R6";
    cfg(2'd2, 16'd2);
    cfg(2'd0, 16'h0020);
    put(2);
    idle(); rd_req_i = 1;
    for (int k = 0; k < 6; k++) begin
      sync0_i = (k == 0);
      cycle();
      chk(out_valid_o === 1'b0, "R6", "sync0 ignored in mode 10", 32'(out_valid_o), 32'd0);
    end
    sync0_i = 0;
    delayed_read(1, 2, "R6");

    tag = "R7";
    get(DEPTH);
    cfg(2'd1, 16'd5);
    cfg(2'd0, 16'h0010);
    put(2);
    idle(); sync0_i = 1; cycle();
    sync0_i = 0; cycle();
    cfg(2'd0, 16'h0010);
    idle(); rd_req_i = 1;
    for (int k = 0; k < 9; k++) begin
      cycle();
      chk(out_valid_o === 1'b0, "R7", "count cleared by mode write", 32'(out_valid_o), 32'd0);
    end
    delayed_read(0, 5, "R7");

    tag = "R8";
    for (int i = 0; i < 4000; i++) begin
      idle();
      if ($urandom_range(39) == 0) begin
        cfg_we_i = 1;
        cfg_addr_i = 2'($urandom_range(2));
        cfg_wdata_i = (cfg_addr_i == 2'd0) ? DLY_W'($urandom_range(63)) : DLY_W'($urandom_range(6));
      end
      if ($urandom_range(7) == 0) sync0_i = ~sync0_i;
      if ($urandom_range(7) == 0) sync1_i = ~sync1_i;
      in_valid_i = 1'($urandom);
      in_data_i  = DW'($urandom);
      rd_req_i   = 1'($urandom);
      cycle();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule